// File: doc/BRIEF.md
# Debug Trace Capture Controller

This block records one trace entry per clock cycle into an on-chip trace store while the program under debug is running. Each entry holds a trace data word and an external trace input bit. Three capture policies are available. Forward capture fills the store from the first running cycle and stops when the store is full. History capture overwrites the store circularly, so it keeps the newest entries before the halt. Window capture records only between an opening trigger address and a closing trigger address.

In window mode a cycle counter adds up every cycle spent inside the window, across several entries into it, so that execution time can be measured. A trigger output marks the valid trigger hits and stays high while the program is halted. After a halt, the store is read through an index that counts from the oldest valid entry. Index 0 is therefore always the earliest sample still held.

The mode and the enable are sampled in the first running cycle of each run. The store depth is 2^AW entries. Production use sets AW to 20. The default is small.

Top module: `trc_capture`

## Requirements
- R1: Under reset, full_o = 0, trig_o = 1, win_cycles_o = 0 and count_o = 0.
- R2: Forward mode (mode_i = 0 or 3) stores one entry for each running cycle, starting with the first running cycle of the run. It stops storing once 2^AW entries are held. Entries captured after that are dropped.
- R3: History mode (mode_i = 1) stores on every running cycle and wraps around. After a halt the store holds the newest min(N, 2^AW) of the N captured entries.
- R4: Window mode (mode_i = 2) opens on a cycle whose address equals trig1_addr_i while the window is closed. It closes on a cycle whose address equals trig2_addr_i while the window is open. Both trigger cycles are stored. A second-trigger match while the window is closed is ignored, and so is a first-trigger match while it is open. The window is closed at the start of each run.
- R5: full_o rises on the cycle after the write that fills the store. It stays high while the program is halted. It returns low on the cycle after the first running cycle of the next run.
- R6: trig_o is a registered flag. It is high in the cycle after a halted cycle, and in the cycle after each valid trigger hit (an opening or a closing, as defined in R4). Otherwise it is low.
- R7: When trc_en_i is 0 at the start of a run, nothing is stored in that run: count_o stays 0 and full_o stays 0.
- R8: Each entry is {ext_i, data_i}, with the external bit in bit position DATA_W.
- R9: In window mode, win_cycles_o counts the cycles spent in the window, including both trigger cycles, across repeated entries into the window. The count runs whether or not tracing is enabled. It is cleared at the start of each run and held while the program is halted.
- R10: count_o gives the number of valid entries. While halted, rd_data_o returns the entry at position rd_idx_i counted from the oldest entry, so that rd_idx_i = 0 .. count_o-1 reads the entries in capture order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | 1 while the program runs, 0 while halted |
| trc_en_i | input | 1 | Tracing enable, sampled at run start |
| mode_i | input | 2 | Capture mode, sampled at run start (0/3 forward, 1 history, 2 window) |
| exec_addr_i | input | ADDR_W | Execution address of the current cycle |
| trig1_addr_i | input | ADDR_W | Window opening address |
| trig2_addr_i | input | ADDR_W | Window closing address |
| data_i | input | DATA_W | Trace data word |
| ext_i | input | 1 | External trace input bit |
| rd_idx_i | input | AW | Read index relative to the oldest entry |
| full_o | output | 1 | Trace store full |
| trig_o | output | 1 | Trigger hit / halted indication |
| win_cycles_o | output | CNT_W | Cycles spent inside the window |
| count_o | output | AW+1 | Number of valid entries |
| oldest_o | output | AW | Physical slot of the oldest entry |
| rd_data_o | output | DATA_W+1 | Entry at the requested relative index |

## Verification
The assertions assume that run_i is synchronous to clk. They also assume the store holds at least two entries, so that a run cannot fill it in its first cycle. Mode, enable and trigger addresses are taken as meaningful only where a run starts; the stimulus changes them only while the program is halted. The read index is moved only during halts, after the last write of a run. The address sequences include a closing match before any opening, a repeated opening match inside the window, and a second entry into the window.

// File: rtl/trc_capture_pkg.sv
package trc_capture_pkg;
  typedef enum logic [1:0] {
    TM_FWD     = 2'd0,
    TM_HIST    = 2'd1,
    TM_WIN     = 2'd2,
    TM_FWD_ALT = 2'd3
  } trc_mode_e;
endpackage

// File: rtl/trc_window.sv
// Ordered two-point window sequencer, in-window cycle counter, trigger flag.
module trc_window #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              start_i,
  input  logic              win_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] trig1_i,
  input  logic [ADDR_W-1:0] trig2_i,
  output logic              in_win_o,
  output logic              trig_o,
  output logic [CNT_W-1:0]  cycles_o
);
  logic             open_q, open_d, open_en, open_eff;
  logic             trig_q, trig_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en, hit1, hit2, in_win;

  always_comb begin
    open_eff = open_q & ~start_i;
    hit1     = run_i & win_en_i & ~open_eff & (addr_i == trig1_i);
    hit2     = run_i & win_en_i &  open_eff & (addr_i == trig2_i);
    in_win   = run_i & win_en_i & (open_eff | hit1);
    open_en  = start_i | hit1 | hit2;
    open_d   = open_eff;
    if (hit1)      open_d = 1'b1;
    else if (hit2) open_d = 1'b0;
    cnt_en = start_i | in_win;
    cnt_d  = start_i ? '0 : cnt_q;
    if (in_win) cnt_d = cnt_d + CNT_W'(1);
    trig_d = ~run_i | hit1 | hit2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      trig_q <= 1'b1;
    end else begin
      if (open_en) open_q <= open_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      trig_q <= trig_d;
    end
  end

  assign in_win_o = in_win;
  assign trig_o   = trig_q;
  assign cycles_o = cnt_q;
endmodule

// File: rtl/trc_wrctl.sv
// Write pointer, valid count, full flag and oldest-slot report.
module trc_wrctl #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          start_i,
  input  logic          en_i,
  input  logic          hist_i,
  input  logic          sample_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic          full_o,
  output logic [AW:0]   count_o,
  output logic [AW-1:0] oldest_o
);
  localparam int          DEPTH   = 1 << AW;
  localparam logic [AW:0] CNT_MAX = (AW+1)'(DEPTH);

  logic [AW-1:0] wptr_q, wptr_d, wptr_eff;
  logic [AW:0]   cnt_q, cnt_d, cnt_eff;
  logic          full_q, full_d, full_eff, we, upd_en;

  always_comb begin
    wptr_eff = start_i ? '0 : wptr_q;
    cnt_eff  = start_i ? '0 : cnt_q;
    full_eff = full_q & ~start_i;
    we       = run_i & en_i & sample_i & (hist_i | ~full_eff);
    upd_en   = start_i | we;
    wptr_d   = we ? wptr_eff + AW'(1) : wptr_eff;
    cnt_d    = (we && cnt_eff != CNT_MAX) ? cnt_eff + (AW+1)'(1) : cnt_eff;
    full_d   = full_eff | (we & (cnt_eff == CNT_MAX - (AW+1)'(1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (upd_en) begin
      wptr_q <= wptr_d;
      cnt_q  <= cnt_d;
      full_q <= full_d;
    end
  end

  assign we_o     = we;
  assign waddr_o  = wptr_eff;
  assign full_o   = full_q;
  assign count_o  = cnt_q;
  assign oldest_o = (hist_i && full_q) ? wptr_q : '0;
endmodule

// File: rtl/trc_mem.sv
// Trace store: one synchronous write port, one combinational read port.
module trc_mem #(
  parameter int AW = 8,
  parameter int W  = 9
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) store[waddr_i] <= wdata_i;
  end

  assign rdata_o = store[raddr_i];
endmodule

// File: rtl/trc_capture.sv
module trc_capture
  import trc_capture_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int AW     = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              trc_en_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] exec_addr_i,
  input  logic [ADDR_W-1:0] trig1_addr_i,
  input  logic [ADDR_W-1:0] trig2_addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ext_i,
  input  logic [AW-1:0]     rd_idx_i,
  output logic              full_o,
  output logic              trig_o,
  output logic [CNT_W-1:0]  win_cycles_o,
  output logic [AW:0]       count_o,
  output logic [AW-1:0]     oldest_o,
  output logic [DATA_W:0]   rd_data_o
);
  localparam int ENTRY_W = DATA_W + 1;

  logic      run_q, en_q, start, en_eff, win_en, hist, in_win, sample, we;
  trc_mode_e mode_q, mode_eff;
  logic [AW-1:0] waddr, raddr;

  always_comb begin
    start    = run_i & ~run_q;
    mode_eff = start ? trc_mode_e'(mode_i) : mode_q;
    en_eff   = start ? trc_en_i : en_q;
    win_en   = (mode_eff == TM_WIN);
    hist     = (mode_eff == TM_HIST);
    sample   = win_en ? in_win : 1'b1;
    raddr    = oldest_o + rd_idx_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= TM_FWD;
      en_q   <= 1'b0;
    end else begin
      run_q <= run_i;
      if (start) begin
        mode_q <= mode_eff;
        en_q   <= en_eff;
      end
    end
  end

  trc_window #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_win (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .start_i(start), .win_en_i(win_en),
    .addr_i(exec_addr_i), .trig1_i(trig1_addr_i), .trig2_i(trig2_addr_i),
    .in_win_o(in_win), .trig_o(trig_o), .cycles_o(win_cycles_o)
  );

  trc_wrctl #(.AW(AW)) u_wr (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .start_i(start), .en_i(en_eff),
    .hist_i(hist), .sample_i(sample), .we_o(we), .waddr_o(waddr),
    .full_o(full_o), .count_o(count_o), .oldest_o(oldest_o)
  );

  trc_mem #(.AW(AW), .W(ENTRY_W)) u_mem (
    .clk(clk), .we_i(we), .waddr_i(waddr), .wdata_i({ext_i, data_i}),
    .raddr_i(raddr), .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/trc_capture_chk.sv
module trc_capture_chk #(
  parameter int AW    = 8,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_i,
  input logic             trc_en_i,
  input logic             full_o,
  input logic             trig_o,
  input logic [CNT_W-1:0] win_cycles_o,
  input logic [AW:0]      count_o
);
  localparam logic [AW:0] CNT_MAX = (AW+1)'(1 << AW);

  p_full_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && full_o) |=> full_o);

  p_full_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_i) |=> !full_o);

  p_full_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> (count_o == CNT_MAX));

  p_trig_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> trig_o);

  p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run_i) && !trc_en_i) |=> (count_o == '0 && !full_o));

  p_win_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(win_cycles_o));

  p_count_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(count_o));

  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CNT_MAX);
endmodule

bind trc_capture trc_capture_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_i(run_i), .trc_en_i(trc_en_i),
  .full_o(full_o), .trig_o(trig_o), .win_cycles_o(win_cycles_o), .count_o(count_o)
);

// File: tb/trc_capture_tb.sv
`timescale 1ns/1ps
module trc_capture_tb;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int AW     = 3;
  localparam int CNT_W  = 16;
  localparam int DEPTH  = 1 << AW;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              run, en, ext;
  logic [1:0]        mode;
  logic [ADDR_W-1:0] exec_addr, t1, t2;
  logic [DATA_W-1:0] data;
  logic [AW-1:0]     rd_idx;
  logic              full_o, trig_o;
  logic [CNT_W-1:0]  win_cycles_o;
  logic [AW:0]       count_o;
  logic [AW-1:0]     oldest_o;
  logic [DATA_W:0]   rd_data_o;

  trc_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .AW(AW), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_i(run), .trc_en_i(en), .mode_i(mode),
    .exec_addr_i(exec_addr), .trig1_addr_i(t1), .trig2_addr_i(t2),
    .data_i(data), .ext_i(ext), .rd_idx_i(rd_idx),
    .full_o(full_o), .trig_o(trig_o), .win_cycles_o(win_cycles_o),
    .count_o(count_o), .oldest_o(oldest_o), .rd_data_o(rd_data_o)
  );

  always #4 clk = ~clk;

  int checks = 0, failures = 0, cyc_n = 0;
  string cur_req = "R2";

  // reference model state
  int m_runq = 0, m_full = 0, m_open = 0, m_win = 0, m_trig = 1, m_mode = 0, m_en = 0;
  logic [DATA_W:0] hist[$];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc_n);
    end
  endtask

  task automatic model_step();
    bit st, h1, h2, inw, samp;
    st = run && (m_runq == 0);
    if (st) begin
      m_mode = mode; m_en = en; m_full = 0; m_open = 0; m_win = 0;
      hist.delete();
    end
    h1 = 0; h2 = 0; inw = 0; samp = 0;
    if (run) begin
      if (m_mode == 2) begin
        h1 = (exec_addr == t1) && (m_open == 0);
        h2 = (exec_addr == t2) && (m_open == 1);
        inw = (m_open == 1) || h1;
        samp = inw;
        if (inw) m_win++;
      end else begin
        samp = 1;
      end
      if (m_en != 0 && samp && (m_mode == 1 || m_full == 0)) begin
        hist.push_back({ext, data});
        if (hist.size() > DEPTH) void'(hist.pop_front());
        if (hist.size() == DEPTH) m_full = 1;
      end
      if (m_mode == 2) begin
        if (h1) m_open = 1;
        else if (h2) m_open = 0;
      end
    end
    m_trig = (!run || h1 || h2) ? 1 : 0;
    m_runq = run ? 1 : 0;
  endtask

  task automatic compare();
    check(full_o == m_full[0], "R5", "full_o", int'(full_o), m_full);
    check(trig_o == m_trig[0], "R6", "trig_o", int'(trig_o), m_trig);
    check(int'(win_cycles_o) == (m_win & 16'hFFFF), "R9", "win_cycles_o", int'(win_cycles_o), m_win);
    check(int'(count_o) == hist.size(), cur_req, "count_o", int'(count_o), hist.size());
  endtask

  task automatic cyc(input bit r, input int a);
    cyc_n++;
    run = r;
    exec_addr = ADDR_W'(a);
    data = DATA_W'(cyc_n * 37 + 11);
    ext = (cyc_n % 3 == 0);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic run_plain(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 16'h0100 + i);
  endtask

  task automatic halt(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 0);
  endtask

  task automatic readback(input string req);
    check(int'(count_o) == hist.size(), req, "readback count", int'(count_o), hist.size());
    for (int i = 0; i < hist.size(); i++) begin
      rd_idx = AW'(i);
      #0.2;
      check(rd_data_o == hist[i], req, $sformatf("entry %0d", i), int'(rd_data_o), int'(hist[i]));
      check(rd_data_o[DATA_W] == hist[i][DATA_W], "R8", $sformatf("ext bit entry %0d", i),
            int'(rd_data_o[DATA_W]), int'(hist[i][DATA_W]));
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; en = 1'b1; mode = 2'd0; ext = 1'b0;
    exec_addr = '0; t1 = 16'h0010; t2 = 16'h0020; data = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(full_o == 1'b0, "R1", "full_o", int'(full_o), 0);
    check(trig_o == 1'b1, "R1", "trig_o", int'(trig_o), 1);
    check(win_cycles_o == '0, "R1", "win_cycles_o", int'(win_cycles_o), 0);
    check(count_o == '0, "R1", "count_o", int'(count_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: forward capture, partial then overfilled
    cur_req = "R2"; mode = 2'd0; en = 1'b1;
    run_plain(5); halt(2); readback("R2");
    run_plain(12); halt(3); readback("R2");
    // alternate forward code, restart clears full (R5)
    mode = 2'd3;
    run_plain(3); halt(1); readback("R2");

    // R3: history capture, wrapped and not wrapped
    cur_req = "R3"; mode = 2'd1;
    run_plain(13); halt(2); readback("R3");
    run_plain(DEPTH); halt(1); readback("R3");
    run_plain(3); halt(1); readback("R10");

    // R4: window capture with ordered triggers
    cur_req = "R4"; mode = 2'd2;
    cyc(1, 16'h0020); cyc(1, 16'h0005); cyc(1, 16'h0010); cyc(1, 16'h0011);
    cyc(1, 16'h0010); cyc(1, 16'h0012); cyc(1, 16'h0020); cyc(1, 16'h0030);
    cyc(1, 16'h0020); cyc(1, 16'h0010); cyc(1, 16'h0020); cyc(1, 16'h0007);
    halt(2); readback("R4");
    // window longer than the store: fills and stops
    cyc(1, 16'h0010);
    for (int i = 0; i < 10; i++) cyc(1, 16'h0040 + i);
    cyc(1, 16'h0020); halt(1); readback("R4");

    // R7: tracing disabled, window counter still runs (R9)
    cur_req = "R7"; en = 1'b0;
    cyc(1, 16'h0010); cyc(1, 16'h0033); cyc(1, 16'h0020); cyc(1, 16'h0001);
    halt(1);
    mode = 2'd1;
    run_plain(12); halt(2); readback("R7");

    finish_run();
  end
endmodule